// File: doc/BRIEF.md
# Framed Serial PCM Channel Port

This block is the digital side of a single-channel PCM codec. It runs on the serial bit clock. A frame sync pulse divides the bit stream into frames of `SLOTS` bit slots: 256 at the default 2.048 MHz bit rate and 125 µs frame period. The channel word sits in slots 0 to 7. On the transmit side, the 8-bit encoded sample is latched at the start of each frame, recoded into the selected line format, and shifted out MSB first, which is the sign bit. The output enable is asserted only while the channel slots are on the line, so an outside driver can release the shared wire for the rest of the frame.

On the receive side, the line is sampled on the falling edge of the bit clock during the same eight slots. The line format is removed with the code that was latched for that frame. The recovered word is loaded into a holding register once per frame, together with a one-cycle valid strobe. Three line codes can be selected:

- plain sign-magnitude;
- true sign with the seven magnitude bits inverted;
- inversion of the even-numbered bits.

Each code is its own inverse, so transmit and receive use the same mapping. A frame pulse that arrives early restarts the frame at slot 0.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, `tx_oe_o`, `tx_line_o`, `rx_valid_o` and `rx_word_o` are all 0. The enable stays low and no receive word is produced until the first frame pulse has been seen.
- R2: Slot numbering repeats every `SLOTS` bit clocks with no frame pulse. After slot `SLOTS-1`, the next cycle is slot 0 of a new frame.
- R3: `frame_sync_i` high at a rising edge makes the cycle that starts at that edge slot 0, whatever slot was in progress. An early pulse truncates the current frame.
- R4: In slots 0 to 7, `tx_oe_o` is 1 and `tx_line_o` carries bit 7-k of the coded word in slot k (MSB first). Both change on the rising edge that starts the slot.
- R5: In slots 8 to `SLOTS-1`, `tx_oe_o` is 0 and `tx_line_o` is held at 0.
- R6: Line code selection `fmt_sel_i`:
  - 0: the word passes unchanged;
  - 1: the word is XORed with 8'h7F (sign bit 7 kept);
  - 2: the word is XORed with 8'h55 (bits 0, 2, 4, 6 inverted);
  - 3: treated as 0.
- R7: `tx_word_i` and `fmt_sel_i` are sampled only at the rising edge that starts slot 0. Later changes within the frame do not alter the transmitted bits or the receive decoding of that frame.
- R8: In slot k (0 to 7), `rx_line_i` is sampled at the falling edge of `clk` and becomes bit 7-k of the received line word.
- R9: At the rising edge that ends slot 7, `rx_word_o` is loaded with the received line word decoded by the frame's latched code (same mapping as R6). `rx_word_o` keeps its value at all other times.
- R10: `rx_valid_o` is high for exactly the one cycle after each rising edge that ends slot 7. A frame cut short before slot 7 produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync_i | input | 1 | Frame pulse, sampled at the rising edge; the next cycle is slot 0 |
| tx_word_i | input | WORD_W | Encoded sample to transmit |
| fmt_sel_i | input | 2 | Line code select (see R6) |
| rx_line_i | input | 1 | Serial receive line, sampled on the falling edge |
| tx_line_o | output | 1 | Serial transmit data, 0 when not driving |
| tx_oe_o | output | 1 | Drive enable for the transmit line (low means high impedance) |
| rx_word_o | output | WORD_W | Last decoded receive word |
| rx_valid_o | output | 1 | One-cycle strobe when `rx_word_o` is updated |

## Verification
The bench builds the port with `WORD_W = 8` and `SLOTS = 16`. The short frame lets every 8-bit transmit value be sent under each of the four code selections, with a distinct receive word in every frame, in about 16k cycles.

Most frames in the sweep are started by a pulse. The frames with code 3 mostly roll over on their own, which exercises the natural wrap. In every frame, the code and word inputs change just after slot 0 to show that they are latched.

A final pass places a frame pulse at every slot position. This covers truncation both before and at the receive strobe.

// File: rtl/pcm_port_pkg.sv
`timescale 1ns/1ps
// Shared types for the framed serial PCM port.
// Assumes: line code select is a 2-bit field; code 3 is reserved and behaves as plain.
package pcm_port_pkg;

    typedef enum logic [1:0] {
        FMT_PLAIN   = 2'd0,
        FMT_MAG_INV = 2'd1,
        FMT_ALT_INV = 2'd2,
        FMT_RSVD    = 2'd3
    } pcm_fmt_e;

endpackage

// File: rtl/pcm_slot_timer.sv
`timescale 1ns/1ps
// Bit-slot counter for the framed port.
// Counts bit clocks within a frame, restarts at slot 0 on a frame pulse or
// after the last slot, and flags whether any frame pulse has been seen.
// Assumes: frame_sync_i is synchronous to clk and sampled at the rising edge.
module pcm_slot_timer #(
    parameter int SLOTS = 256,
    parameter int SW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_sync_i,
    output logic [SW-1:0] slot_o,
    output logic          live_o,
    output logic [SW-1:0] nxt_slot_o,
    output logic          nxt_live_o
);

    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

    logic [SW-1:0] slot_q;
    logic          live_q;

    // Next slot: a pulse forces slot 0, otherwise count with wrap.
    always_comb begin
        if (frame_sync_i) begin
            nxt_slot_o = '0;
        end else if (slot_q == LAST_SLOT) begin
            nxt_slot_o = '0;
        end else begin
            nxt_slot_o = slot_q + SW'(1);
        end
        nxt_live_o = live_q | frame_sync_i;
    end

    // Slot and lock registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            live_q <= 1'b0;
        end else begin
            slot_q <= nxt_slot_o;
            live_q <= nxt_live_o;
        end
    end

    assign slot_o = slot_q;
    assign live_o = live_q;

    AST_FP_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync_i |=> (slot_o == '0) && live_o); // R3
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_sync_i && slot_o == LAST_SLOT) |=> (slot_o == '0)); // R2
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_sync_i && slot_o != LAST_SLOT) |=> (slot_o == $past(slot_o) + SW'(1))); // R2
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        live_o |=> live_o); // R1

endmodule

// File: rtl/pcm_code_map.sv
`timescale 1ns/1ps
// Line code mapping between the coded sample and the bits on the wire.
// Every mapping is an XOR with a fixed mask, so the same map encodes and decodes.
// Assumes: the word's top bit is the sign.
module pcm_code_map
    import pcm_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] word_i,
    input  pcm_fmt_e     fmt_i,
    output logic [W-1:0] word_o
);

    logic [W-1:0] mag_mask;
    logic [W-1:0] alt_mask;

    // Build the masks bit by bit: all but the sign, and the even positions.
    for (genvar g = 0; g < W; g++) begin : g_mask
        assign mag_mask[g] = (g != W - 1);
        assign alt_mask[g] = ((g % 2) == 0);
    end

    // Select the mask for the chosen code; the reserved code passes the word unchanged.
    always_comb begin
        case (fmt_i)
            FMT_MAG_INV: word_o = word_i ^ mag_mask;
            FMT_ALT_INV: word_o = word_i ^ alt_mask;
            default:     word_o = word_i;
        endcase
    end

endmodule

// File: rtl/pcm_tx_serializer.sv
`timescale 1ns/1ps
// Transmit side: latches the sample and the code at frame start, codes the
// sample, and shifts it out MSB first in the first W slots with the drive enable high.
// Assumes: SLOTS > W; output bits change on the rising edge of clk.
module pcm_tx_serializer
    import pcm_port_pkg::*;
#(
    parameter int W  = 8,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] slot_i,
    input  logic          live_i,
    input  logic [SW-1:0] nxt_slot_i,
    input  logic          nxt_live_i,
    input  logic [W-1:0]  word_i,
    input  pcm_fmt_e      fmt_i,
    output pcm_fmt_e      fmt_q_o,
    output logic          tx_bit_o,
    output logic          tx_oe_o
);

    logic [W-1:0] coded;
    logic [W-1:0] sh_q;
    pcm_fmt_e     fmt_q;
    logic         start_frame;
    logic         in_window;

    pcm_code_map #(.W(W)) u_enc (
        .word_i (word_i),
        .fmt_i  (fmt_i),
        .word_o (coded)
    );

    // Decode whether the coming cycle is slot 0 or inside the channel slots.
    always_comb begin
        start_frame = nxt_live_i && (nxt_slot_i == '0);
        in_window   = nxt_live_i && (nxt_slot_i < SW'(W));
    end

    // Latch the code and load or shift the word; drive the line only in the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            fmt_q    <= FMT_PLAIN;
            tx_bit_o <= 1'b0;
            tx_oe_o  <= 1'b0;
        end else begin
            tx_oe_o <= in_window;
            if (start_frame) begin
                fmt_q    <= fmt_i;
                tx_bit_o <= coded[W-1];
                sh_q     <= {coded[W-2:0], 1'b0};
            end else if (in_window) begin
                tx_bit_o <= sh_q[W-1];
                sh_q     <= {sh_q[W-2:0], 1'b0};
            end else begin
                tx_bit_o <= 1'b0;
            end
        end
    end

    assign fmt_q_o = fmt_q;

    AST_OE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oe_o |-> (live_i && slot_i < SW'(W))); // R4
    AST_WINDOW_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (live_i && slot_i < SW'(W)) |-> tx_oe_o); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe_o |-> !tx_bit_o); // R5
    AST_NO_DRIVE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !live_i |-> !tx_oe_o); // R1

endmodule

// File: rtl/pcm_rx_deserializer.sv
`timescale 1ns/1ps
// Receive side: samples the line on the falling edge during the first W
// slots, then decodes and loads the word with a one-cycle strobe at the
// rising edge that ends the last channel slot.
// Assumes: fmt_i is the code latched at the start of the current frame.
module pcm_rx_deserializer
    import pcm_port_pkg::*;
#(
    parameter int W  = 8,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] slot_i,
    input  logic          live_i,
    input  logic          rx_bit_i,
    input  pcm_fmt_e      fmt_i,
    output logic [W-1:0]  rx_word_o,
    output logic          rx_valid_o
);

    logic [W-1:0] sh_q;
    logic [W-1:0] decoded;
    logic         last_slot;

    pcm_code_map #(.W(W)) u_dec (
        .word_i (sh_q),
        .fmt_i  (fmt_i),
        .word_o (decoded)
    );

    // Flag the final channel slot of a live frame.
    always_comb begin
        last_slot = live_i && (slot_i == SW'(W - 1));
    end

    // Falling-edge capture of the line, MSB first, during the channel slots.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (live_i && slot_i < SW'(W)) begin
            sh_q <= {sh_q[W-2:0], rx_bit_i};
        end
    end

    // Load the decoded word and strobe once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word_o  <= '0;
            rx_valid_o <= 1'b0;
        end else begin
            rx_valid_o <= last_slot;
            if (last_slot) begin
                rx_word_o <= decoded;
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o); // R10
    AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> (slot_i == SW'(W) || slot_i == '0)); // R9
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_o |=> (rx_valid_o || $stable(rx_word_o))); // R9

endmodule

// File: rtl/pcm_serial_port.sv
`timescale 1ns/1ps
// Framed serial PCM port: slot timing, transmit serializer with line coding,
// and receive deserializer with the matching decoding.
// Assumes: clk is the serial bit clock, frame_sync_i is synchronous to it,
// SLOTS > WORD_W, and the line itself is tri-stated by tx_oe_o outside the block.
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int SLOTS  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync_i,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic [1:0]        fmt_sel_i,
    input  logic              rx_line_i,
    output logic              tx_line_o,
    output logic              tx_oe_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o
);

    localparam int SW = $clog2(SLOTS);

    logic [SW-1:0] slot;
    logic          live;
    logic [SW-1:0] nxt_slot;
    logic          nxt_live;
    pcm_fmt_e      fmt_in;
    pcm_fmt_e      fmt_frame;

    // Map the raw select pins onto the code type.
    always_comb begin
        fmt_in = pcm_fmt_e'(fmt_sel_i);
    end

    pcm_slot_timer #(.SLOTS(SLOTS), .SW(SW)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_sync_i (frame_sync_i),
        .slot_o       (slot),
        .live_o       (live),
        .nxt_slot_o   (nxt_slot),
        .nxt_live_o   (nxt_live)
    );

    pcm_tx_serializer #(.W(WORD_W), .SW(SW)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_i     (slot),
        .live_i     (live),
        .nxt_slot_i (nxt_slot),
        .nxt_live_i (nxt_live),
        .word_i     (tx_word_i),
        .fmt_i      (fmt_in),
        .fmt_q_o    (fmt_frame),
        .tx_bit_o   (tx_line_o),
        .tx_oe_o    (tx_oe_o)
    );

    pcm_rx_deserializer #(.W(WORD_W), .SW(SW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_i     (slot),
        .live_i     (live),
        .rx_bit_i   (rx_line_i),
        .fmt_i      (fmt_frame),
        .rx_word_o  (rx_word_o),
        .rx_valid_o (rx_valid_o)
    );

endmodule

// File: tb/pcm_serial_port_test.sv
`timescale 1ns/1ps
module pcm_serial_port_test;

    localparam int S = 16;
    localparam int WATCHDOG_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync_i = 1'b0;
    logic [7:0] tx_word_i = 8'h00;
    logic [1:0] fmt_sel_i = 2'd0;
    logic       rx_line_i = 1'b1;
    logic       tx_line_o;
    logic       tx_oe_o;
    logic [7:0] rx_word_o;
    logic       rx_valid_o;

    pcm_serial_port #(.WORD_W(8), .SLOTS(S)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_sync_i (frame_sync_i),
        .tx_word_i    (tx_word_i),
        .fmt_sel_i    (fmt_sel_i),
        .rx_line_i    (rx_line_i),
        .tx_line_o    (tx_line_o),
        .tx_oe_o      (tx_oe_o),
        .rx_word_o    (rx_word_o),
        .rx_valid_o   (rx_valid_o)
    );

    always #4 clk = ~clk;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string ptag  = "R1 reset";

    // Bench model state.
    bit         m_live = 1'b0;
    int         m_slot = 0;
    logic [7:0] m_txc = 8'h00;
    logic [1:0] m_mode = 2'd0;
    logic [7:0] m_rword = 8'h00;
    logic [7:0] m_outword = 8'h00;
    logic [7:0] next_rword = 8'h00;

    function automatic logic [7:0] bfmt(logic [7:0] w, logic [1:0] m);
        case (m)
            2'd1:    return w ^ 8'b0111_1111;
            2'd2:    return w ^ 8'b0101_0101;
            default: return w;
        endcase
    endfunction

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", ptag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // One bit clock: apply the pulse, advance the model, compare, drive rx for the new slot.
    task automatic step(input logic fp);
        logic       exp_valid;
        logic       exp_oe;
        logic       exp_bit;
        logic [7:0] lw;
        frame_sync_i = fp;
        @(posedge clk);
        #1;
        exp_valid = m_live && (m_slot == 7);
        if (exp_valid) m_outword = m_rword;
        if (fp) begin
            m_slot = 0;
            m_live = 1'b1;
        end else begin
            m_slot = (m_slot == S - 1) ? 0 : m_slot + 1;
        end
        if (m_live && m_slot == 0) begin
            m_txc   = bfmt(tx_word_i, fmt_sel_i);
            m_mode  = fmt_sel_i;
            m_rword = next_rword;
        end
        exp_oe  = m_live && (m_slot < 8);
        exp_bit = exp_oe ? m_txc[7 - m_slot] : 1'b0;
        chk("R4/R5 oe", {7'd0, tx_oe_o}, {7'd0, exp_oe});
        chk("R4/R6/R7 tx bit", {7'd0, tx_line_o}, {7'd0, exp_bit});
        chk("R10 rx valid", {7'd0, rx_valid_o}, {7'd0, exp_valid});
        chk("R8/R9 rx word", rx_word_o, m_outword);
        frame_sync_i = 1'b0;
        if (exp_oe) begin
            lw = bfmt(m_rword, m_mode);
            rx_line_i = lw[7 - m_slot];
        end else begin
            rx_line_i = m_slot[0];
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        // R1: reset state of every output.
        rst_n = 1'b0;
        repeat (4) begin
            @(posedge clk);
            #1;
            chk("R1 oe", {7'd0, tx_oe_o}, 8'd0);
            chk("R1 line", {7'd0, tx_line_o}, 8'd0);
            chk("R1 valid", {7'd0, rx_valid_o}, 8'd0);
            chk("R1 word", rx_word_o, 8'd0);
        end
        rst_n = 1'b1;

        // R1: no drive and no strobe before the first frame pulse.
        ptag = "R1 prelock";
        for (int i = 0; i < 40; i++) begin
            tx_word_i = 8'(i * 13);
            step(1'b0);
        end

        // R2 R4 R5 R6 R7 R8 R9 R10: every word under every code; inputs change after slot 0.
        ptag = "R2 R4 R5 R6 R7 R8 R9 R10 sweep";
        for (int m = 0; m < 4; m++) begin
            for (int w = 0; w < 256; w++) begin
                tx_word_i  = 8'(w);
                fmt_sel_i  = 2'(m);
                next_rword = 8'(w * 73 + m * 29 + 5);
                step((m != 3) || (w % 4 == 0));
                tx_word_i = ~8'(w);
                fmt_sel_i = 2'(m) ^ 2'd1;
                for (int k = 1; k < S; k++) step(1'b0);
            end
        end

        // R3: frame pulse at every slot position, including the last channel slot.
        ptag = "R3 resync";
        for (int e = 1; e <= S; e++) begin
            tx_word_i  = 8'(e * 29 + 3);
            fmt_sel_i  = 2'(e % 3);
            next_rword = 8'(e * 101 + 7);
            step(1'b1);
            for (int k = 1; k < e; k++) step(1'b0);
        end
        for (int k = 0; k < 2 * S; k++) step(1'b0);

        summary();
    end

endmodule